// File: doc/BRIEF.md
# Debug Breakpoint and Code Patch Unit

This block sits next to a processor's fetch path and watches every access it is shown. Each access carries a type: instruction fetch or literal (data) load. Six comparators are armed for instruction fetches and two for literal loads. When an armed comparator sees its word address, the unit does one of two things. It either reports a remapped address inside a patch area of system memory, so the bus can serve patched code or constants, or it raises a breakpoint request for the halt logic. The match result is combinational, so it is valid in the same cycle as the access.

Software sets the unit up through a small word-addressed register bus. A control word holds the global enable, guarded by a key bit that must be set in the same write. A base register points at the patch area, and there is one configuration word for each comparator. When several comparators match at once, the lowest-numbered one decides the result.

Top module: `bpu_patch_unit`

## Requirements
- R1: After synchronous reset the control word reads 0x0000_0260, the base and every comparator word read 0, and no remap or breakpoint is reported.
- R2: A write to the control word at offset 0x000 takes effect only if bit 1 of the written data is 1. Otherwise the entire write is dropped.
- R3: The control word is laid out as follows. Bit 0 is the enable. Bits 7:4 hold instruction-comparator count bits 3:0 (value 6). Bits 11:8 hold the literal-comparator count (value 2). Bits 14:12 hold count bits 6:4. All other bits, the key bit included, read 0. No write changes the count fields or the bits that read 0.
- R4: While the enable bit is 0, no access produces a remap or a breakpoint.
- R5: A comparator matches when all of the following hold: its bit 0 is set, access address bits 31:29 are 0, and address bits 28:2 equal its bits 28:2. For a remap result, remap_addr equals the base plus 4 times the comparator index plus access address bits 1:0.
- R6: Instruction fetches are compared only against comparators 0 to 5, at offsets 0x008 to 0x01C. Literal loads are compared only against comparators 6 and 7, at offsets 0x020 and 0x024. Literal comparators always remap.
- R7: Bits 31:30 of an instruction comparator select its action. 00 remaps. 01 breaks only when address bit 1 is 0. 10 breaks only when address bit 1 is 1. 11 breaks on either. A breakpoint result raises bkpt_req and leaves remap_valid low.
- R8: When several comparators match in one cycle, the lowest-numbered one sets the result.
- R9: The base register at 0x004 keeps bits 31:5 and reads bits 4:0 as 0. Comparator words read bits 1 and 29 as 0, and literal comparators also read bits 31:30 as 0.
- R10: Offsets beyond the last comparator read 0, and writes to them change nothing.
- R11: With acc_valid low, both remap_valid and bkpt_req stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset (bits 1:0 ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_is_lit | input | 1 | 1 for a literal load, 0 for an instruction fetch |
| acc_addr | input | 32 | Access byte address |
| remap_valid | output | 1 | Access is redirected to remap_addr |
| remap_addr | output | 32 | Redirected address, 0 when remap_valid is low |
| bkpt_req | output | 1 | Breakpoint request |

## Verification
The bench targets the control-word key. A design that ignored the key would let a keyless write of zero clear the enable. It also checks the halfword selection in the breakpoint modes, where a swapped decode would break on the wrong half of a word. Priority is tested by arming two comparators with the same address and then disarming the lower one, which exposes a wrong scan direction through the remap offset. Cross-type tests send literal loads to instruction-comparator addresses and fetches to literal addresses; a design that shared comparators across types would match on these. Readback of masked bits, unmapped offsets and addresses with high bits set catches sloppy decode.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    parameter int DEF_N_INSN = 6;
    parameter int DEF_N_LIT  = 2;
    parameter int DEF_AW     = 12;

    typedef enum logic [1:0] {
        MODE_REMAP   = 2'b00,
        MODE_BK_LO   = 2'b01,
        MODE_BK_HI   = 2'b10,
        MODE_BK_BOTH = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        cmp_mode_e   mode;
        logic [26:0] word;
        logic        en;
    } cmp_cfg_t;

    // Control image: counts are read-only, key reads zero.
    function automatic logic [31:0] ctrl_image(input logic en, input int n_insn, input int n_lit);
        logic [6:0] ni;
        logic [3:0] nl;
        ni = 7'(n_insn);
        nl = 4'(n_lit);
        return {17'b0, ni[6:4], nl, ni[3:0], 2'b00, 1'b0, en};
    endfunction

    function automatic logic [31:0] cmp_image(input cmp_cfg_t c);
        return {c.mode, 1'b0, c.word, 1'b0, c.en};
    endfunction

    function automatic cmp_cfg_t cmp_decode(input logic [31:0] d, input logic is_lit);
        cmp_cfg_t c;
        c.mode = is_lit ? MODE_REMAP : cmp_mode_e'(d[31:30]);
        c.word = d[28:2];
        c.en   = d[0];
        return c;
    endfunction

endpackage

// File: rtl/bpu_regfile.sv
module bpu_regfile
    import bpu_pkg::*;
#(
    parameter int N_INSN = DEF_N_INSN,
    parameter int N_LIT  = DEF_N_LIT,
    parameter int AW     = DEF_AW
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_we,
    input  logic [AW-1:0]               reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic                        ctrl_en,
    output logic [26:0]                 base_hi,
    output cmp_cfg_t [N_INSN+N_LIT-1:0] cmp_cfg
);
    localparam int N_CMP  = N_INSN + N_LIT;
    localparam int WORD_W = AW - 2;
    localparam int CMP_W0 = 2;

    logic [WORD_W-1:0] word_sel;
    logic              unused_bits;

    assign word_sel    = reg_addr[AW-1:2];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[29]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en <= 1'b0;
        end else if (reg_we && word_sel == WORD_W'(0) && reg_wdata[1]) begin
            ctrl_en <= reg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
        end else if (reg_we && word_sel == WORD_W'(1)) begin
            base_hi <= reg_wdata[31:5];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_cfg <= '0;
        end else if (reg_we) begin
            for (int i = 0; i < N_CMP; i++) begin
                if (word_sel == WORD_W'(CMP_W0 + i)) begin
                    cmp_cfg[i] <= cmp_decode(reg_wdata, i >= N_INSN);
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (word_sel == WORD_W'(0)) begin
            reg_rdata = ctrl_image(ctrl_en, N_INSN, N_LIT);
        end else if (word_sel == WORD_W'(1)) begin
            reg_rdata = {base_hi, 5'b0};
        end
        for (int i = 0; i < N_CMP; i++) begin
            if (word_sel == WORD_W'(CMP_W0 + i)) begin
                reg_rdata = cmp_image(cmp_cfg[i]);
            end
        end
    end

endmodule

// File: rtl/bpu_cmp.sv
module bpu_cmp
    import bpu_pkg::*;
#(
    parameter bit IS_LIT = 1'b0
) (
    input  cmp_cfg_t    cfg,
    input  logic        acc_valid,
    input  logic        acc_is_lit,
    input  logic [31:0] acc_addr,
    output logic        hit,
    output logic        bkpt
);
    logic half_ok;
    logic addr_ok;
    logic unused_lsb;

    assign unused_lsb = acc_addr[0];
    assign addr_ok    = (acc_addr[31:29] == 3'b000) && (acc_addr[28:2] == cfg.word);

    always_comb begin
        unique case (cfg.mode)
            MODE_BK_LO: half_ok = IS_LIT ? 1'b1 : !acc_addr[1];
            MODE_BK_HI: half_ok = IS_LIT ? 1'b1 : acc_addr[1];
            default:    half_ok = 1'b1;
        endcase
    end

    assign hit  = acc_valid && cfg.en && (acc_is_lit == IS_LIT) && addr_ok && half_ok;
    assign bkpt = !IS_LIT && (cfg.mode != MODE_REMAP);

endmodule

// File: rtl/bpu_prio.sv
module bpu_prio #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hit_vec,
    input  logic [N-1:0]     bkpt_vec,
    output logic             found,
    output logic             win_bkpt,
    output logic [IDX_W-1:0] win_idx
);
    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        found    = 1'b0;
        win_bkpt = 1'b0;
        win_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found    = 1'b1;
                win_bkpt = bkpt_vec[i];
                win_idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bpu_patch_unit.sv
module bpu_patch_unit
    import bpu_pkg::*;
#(
    parameter int N_INSN = DEF_N_INSN,
    parameter int N_LIT  = DEF_N_LIT,
    parameter int AW     = DEF_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          acc_valid,
    input  logic          acc_is_lit,
    input  logic [31:0]   acc_addr,
    output logic          remap_valid,
    output logic [31:0]   remap_addr,
    output logic          bkpt_req
);
    localparam int N_CMP = N_INSN + N_LIT;
    localparam int IDX_W = $clog2(N_CMP);

    logic                  ctrl_en;
    logic [26:0]           base_hi;
    cmp_cfg_t [N_CMP-1:0]  cmp_cfg;
    logic [N_CMP-1:0]      hit_vec;
    logic [N_CMP-1:0]      bkpt_vec;
    logic                  found;
    logic                  win_bkpt;
    logic [IDX_W-1:0]      win_idx;

    bpu_regfile #(.N_INSN(N_INSN), .N_LIT(N_LIT), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl_en   (ctrl_en),
        .base_hi   (base_hi),
        .cmp_cfg   (cmp_cfg)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        bpu_cmp #(.IS_LIT(g >= N_INSN)) u_cmp (
            .cfg        (cmp_cfg[g]),
            .acc_valid  (acc_valid),
            .acc_is_lit (acc_is_lit),
            .acc_addr   (acc_addr),
            .hit        (hit_vec[g]),
            .bkpt       (bkpt_vec[g])
        );
    end

    bpu_prio #(.N(N_CMP), .IDX_W(IDX_W)) u_prio (
        .hit_vec  (hit_vec),
        .bkpt_vec (bkpt_vec),
        .found    (found),
        .win_bkpt (win_bkpt),
        .win_idx  (win_idx)
    );

    assign remap_valid = ctrl_en && found && !win_bkpt;
    assign bkpt_req    = ctrl_en && found && win_bkpt;
    assign remap_addr  = remap_valid
                       ? ({base_hi, 5'b0} + {{(30-IDX_W){1'b0}}, win_idx, 2'b00} + {30'b0, acc_addr[1:0]})
                       : 32'h0;

endmodule

// File: rtl/bpu_patch_unit_chk.sv
module bpu_patch_unit_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          acc_valid,
    input logic          acc_is_lit,
    input logic [31:0]   acc_addr,
    input logic          ctrl_en,
    input logic          remap_valid,
    input logic [31:0]   remap_addr,
    input logic          bkpt_req
);
    logic unused_chk;
    assign unused_chk = ^{reg_wdata[31:2], reg_wdata[0], reg_addr[1:0], acc_addr[31:2]};

    AST_KEYLESS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr[AW-1:2] == '0 && !reg_wdata[1]) |=> $stable(ctrl_en)); // R2

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> (!remap_valid && !bkpt_req)); // R4

    AST_REMAP_BYTE_KEPT: assert property (@(posedge clk) disable iff (rst)
        remap_valid |-> (remap_addr[1:0] == acc_addr[1:0])); // R5

    AST_LIT_NO_BKPT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_is_lit) |-> !bkpt_req); // R6

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(remap_valid && bkpt_req)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!remap_valid && !bkpt_req)); // R11

endmodule

bind bpu_patch_unit bpu_patch_unit_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .acc_valid   (acc_valid),
    .acc_is_lit  (acc_is_lit),
    .acc_addr    (acc_addr),
    .ctrl_en     (ctrl_en),
    .remap_valid (remap_valid),
    .remap_addr  (remap_addr),
    .bkpt_req    (bkpt_req)
);

// File: tb/bpu_patch_unit_tb.sv
module bpu_patch_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;
    localparam logic [31:0] BASE = 32'h2000_1000;

    // {is_lit, addr, exp_remap_valid, exp_bkpt, exp_remap_addr}
    localparam logic [66:0] VEC [NV] = '{
        {1'b0, 32'h0000_0102, 1'b1, 1'b0, 32'h2000_1002}, // R5 R8 cmp0 beats cmp4
        {1'b0, 32'h0000_0200, 1'b0, 1'b1, 32'h0},         // R7 low half
        {1'b0, 32'h0000_0202, 1'b0, 1'b0, 32'h0},         // R7 low-only misses high
        {1'b0, 32'h0000_0300, 1'b0, 1'b0, 32'h0},         // R7 high-only misses low
        {1'b0, 32'h0000_0302, 1'b0, 1'b1, 32'h0},         // R7 high half
        {1'b0, 32'h0000_0400, 1'b0, 1'b1, 32'h0},         // R7 both
        {1'b0, 32'h0000_0402, 1'b0, 1'b1, 32'h0},         // R7 both
        {1'b0, 32'h0000_0600, 1'b0, 1'b0, 32'h0},         // R5 disarmed cmp5
        {1'b1, 32'h0000_0800, 1'b1, 1'b0, 32'h2000_1018}, // R6 literal index 6
        {1'b1, 32'h0000_0901, 1'b1, 1'b0, 32'h2000_101D}, // R6 literal index 7
        {1'b0, 32'h0000_0800, 1'b0, 1'b0, 32'h0},         // R6 fetch ignores literal cmp
        {1'b1, 32'h0000_0100, 1'b0, 1'b0, 32'h0},         // R6 literal ignores fetch cmp
        {1'b0, 32'h2000_0100, 1'b0, 1'b0, 32'h0}          // R5 high bits set
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_is_lit = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        remap_valid;
    logic [31:0] remap_addr;
    logic        bkpt_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpu_patch_unit u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_is_lit(acc_is_lit), .acc_addr(acc_addr), .remap_valid(remap_valid),
        .remap_addr(remap_addr), .bkpt_req(bkpt_req)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic acc(input string req, input logic v, input logic lit, input logic [31:0] a,
                       input logic erv, input logic ebk, input logic [31:0] ea);
        @(negedge clk);
        acc_valid = v; acc_is_lit = lit; acc_addr = a;
        #1;
        check(req, {remap_valid, bkpt_req, remap_addr[29:0]}, {erv, ebk, ea[29:0]});
        check(req, {30'b0, remap_addr[31:30]}, {30'b0, ea[31:30]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=timeout exp=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd("R1 ctrl", 12'h000, 32'h0000_0260);
        rd("R1 base", 12'h004, 32'h0);
        rd("R1 cmp0", 12'h008, 32'h0);
        rd("R1 cmp7", 12'h024, 32'h0);
        acc("R1 outputs", 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);

        // R3 read-only and reserved control bits
        wr(12'h000, 32'hFFFF_FFFF);
        rd("R3 ctrl all ones", 12'h000, 32'h0000_0261);
        // R2 keyless write dropped
        wr(12'h000, 32'h0000_0000);
        rd("R2 keyless kept", 12'h000, 32'h0000_0261);

        // R9 masked readback
        wr(12'h004, 32'hFFFF_FFFF);
        rd("R9 base", 12'h004, 32'hFFFF_FFE0);
        wr(12'h00C, 32'hFFFF_FFFF);
        rd("R9 insn cmp", 12'h00C, 32'hDFFF_FFFD);
        wr(12'h020, 32'hFFFF_FFFF);
        rd("R9 lit cmp", 12'h020, 32'h1FFF_FFFD);

        // R10 unmapped offsets
        wr(12'h028, 32'hFFFF_FFFF);
        rd("R10 unmapped 028", 12'h028, 32'h0);
        rd("R10 unmapped 100", 12'h100, 32'h0);
        rd("R10 neighbour cmp7", 12'h024, 32'h0);

        // configuration
        wr(12'h004, BASE);
        wr(12'h008, 32'h0000_0101);
        wr(12'h00C, 32'h4000_0201);
        wr(12'h010, 32'h8000_0301);
        wr(12'h014, 32'hC000_0401);
        wr(12'h018, 32'h0000_0101);
        wr(12'h01C, 32'h0000_0600);
        wr(12'h020, 32'h0000_0801);
        wr(12'h024, 32'h0000_0901);

        for (int i = 0; i < NV; i++) begin
            acc($sformatf("R5/R6/R7/R8 vector %0d", i), 1'b1, VEC[i][66], VEC[i][65:34],
                VEC[i][33], VEC[i][32], VEC[i][31:0]);
        end

        // R11 idle access
        acc("R11 idle", 1'b0, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 32'h0);

        // R4 global disable with key
        wr(12'h000, 32'h0000_0002);
        rd("R4 ctrl off", 12'h000, 32'h0000_0260);
        acc("R4 disabled remap", 1'b1, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 32'h0);
        acc("R4 disabled bkpt", 1'b1, 1'b0, 32'h0000_0400, 1'b0, 1'b0, 32'h0);
        wr(12'h000, 32'h0000_0003);

        // R8 lower comparator disarmed, next in line wins
        wr(12'h008, 32'h0000_0100);
        acc("R8 fallback cmp4", 1'b1, 1'b0, 32'h0000_0101, 1'b1, 1'b0, 32'h2000_1011);

        // R8 breakpoint comparator below a remap one wins
        wr(12'h008, 32'hC000_0101);
        acc("R8 bkpt wins", 1'b1, 1'b0, 32'h0000_0100, 1'b0, 1'b1, 32'h0);

        finish_run();
    end

endmodule